// File: doc/BRIEF.md
# Time Calendar Counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle tick at 1 Hz starts an update cycle. A warning flag rises first. After a fixed lead time the whole chain advances by one second. The flag then stays high for a fixed busy time and falls with a one-cycle done pulse. Software can poll the flag or wait for the pulse to know when the counts are stable.

Each count is held as a byte, in either packed BCD or plain binary. A mode input selects the format. Another input selects 24-hour or 12-hour hours, and the 12-hour form carries a PM flag in bit 7 of the hours byte. A hold input freezes the chain so that a host can load a consistent time through the write port. An optional daylight-saving rule moves the clock forward in spring and back in autumn. Three alarm bytes are compared with seconds, minutes and hours at the end of each update cycle.

Top module: `rtc_calendar_core`

## Requirements
- R1: A synchronous reset sets seconds, minutes, hours and year to 0, day of week, date and month to 1, all alarm bytes to 0, and drives `uip`, `upd_done` and `alarm_hit` low.
- R2: A `tick_1hz` seen at a clock edge while `ctl_set` is 0 and no update is running raises `uip` after that edge. The counts advance at the edge LEAD_CYC cycles later. UPD_CYC cycles after that, `uip` falls and `upd_done` is high for exactly one cycle.
- R3: While `ctl_set` is 1, a tick starts no update cycle. Raising `ctl_set` during the lead time ends the cycle with no advance and no done pulse.
- R4: With `ctl_binary`=1 and `ctl_h24`=1, seconds and minutes wrap 59 to 0, hours wrap 23 to 0, and each wrap carries into the next field.
- R5: With `ctl_binary`=0, each byte holds two BCD digits with the tens digit in bits 7:4. For example, 09:59:59 advances to 10:00:00, stored as hours 0x10, minutes 0x00 and seconds 0x00.
- R6: With `ctl_h24`=0, hours run 12, 1 … 11, and bit 7 is set for PM. 11:59:59 AM advances to 12 PM, 12:59:59 PM advances to 1 PM, and 11:59:59 PM advances to 12 AM and rolls the date.
- R7: At midnight the date wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 1, and year 99 wraps to 0.
- R8: Day of week counts 1 to 7 and advances to 1 after 7 at midnight. Value 1 means Sunday.
- R9: With `ctl_dst`=1, 1:59:59 on a Sunday in April with date 1 to 7 advances to 3:00:00.
- R10: With `ctl_dst`=1, 1:59:59 on a Sunday in October with date 25 or later advances to 1:00:00. This happens only once, so the repeated hour then counts on to 2:00:00.
- R11: `alarm_hit` pulses together with `upd_done` when each of seconds, minutes and hours equals its alarm byte. An alarm byte with bits 7:6 equal to 11 matches any value.
- R12: A host write in the same cycle as the advance sets the written byte to the written value. All other bytes advance normally, using carries computed from their values before the advance.
- R13: `wr_en` writes `wr_data` into the byte chosen by `wr_addr`. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes and 9 alarm hours. Other addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| ctl_set | input | 1 | Hold: blocks update cycles |
| ctl_binary | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| ctl_h24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| ctl_dst | input | 1 | Enables daylight-saving jumps |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write byte address |
| wr_data | input | 8 | Host write data |
| out_sec | output | 8 | Seconds |
| out_min | output | 8 | Minutes |
| out_hour | output | 8 | Hours |
| out_dow | output | 8 | Day of week |
| out_date | output | 8 | Day of month |
| out_month | output | 8 | Month |
| out_year | output | 8 | Year |
| uip | output | 1 | Update cycle in progress |
| upd_done | output | 1 | One-cycle pulse at the end of an update cycle |
| alarm_hit | output | 1 | One-cycle pulse when the alarm matches |

## Verification
A host write and the once-per-second advance can fall on the same clock edge. The bench provokes this by timing a write to the edge that lies exactly LEAD_CYC cycles after the tick. It writes seconds while the old value is 59, so the minute carry must come from the old 59 while the seconds byte takes the written value. The cycle-level model in the bench applies the advance first and the write second. It is compared with every output on every clock, and a directed check confirms both the written byte and the carried minute.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int N_ALM  = 3;

  localparam int A_SEC = 0;
  localparam int A_MIN = 1;
  localparam int A_HR  = 2;
  localparam int A_DOW = 3;
  localparam int A_DAT = 4;
  localparam int A_MON = 5;
  localparam int A_YR  = 6;
  localparam int A_ALS = 7;
  localparam int A_ALM = 8;
  localparam int A_ALH = 9;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t sec;
    byte_t mnt;
    byte_t hour;
    byte_t dow;
    byte_t date;
    byte_t mon;
    byte_t year;
  } time_t;

  localparam time_t RESET_TIME = '{sec: 8'h00, mnt: 8'h00, hour: 8'h00,
                                   dow: 8'h01, date: 8'h01, mon: 8'h01, year: 8'h00};

  typedef enum logic [1:0] {SQ_IDLE, SQ_WARN, SQ_BUSY} seq_t;

  function automatic byte_t from_fmt(input byte_t v, input logic bin);
    return bin ? v : (8'(v[7:4]) * 8'd10 + 8'(v[3:0]));
  endfunction

  function automatic byte_t to_fmt(input byte_t v, input logic bin);
    return bin ? v : {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic byte_t month_days(input byte_t mo, input byte_t yr);
    if (mo == 8'd2) return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
    if (mo == 8'd4 || mo == 8'd6 || mo == 8'd9 || mo == 8'd11) return 8'd30;
    return 8'd31;
  endfunction
endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_pkg::*;
#(
  parameter int LEAD_CYC = 4,
  parameter int UPD_CYC  = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  output logic uip,
  output logic adv,
  output logic fin,
  output logic done
);
  localparam int MAXC = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  seq_t          st;
  logic [CW-1:0] cnt;

  assign adv = (st == SQ_WARN) && (cnt == '0) && !hold;
  assign fin = (st == SQ_BUSY) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      uip  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (tick && !hold) begin
          st  <= SQ_WARN;
          cnt <= CW'(LEAD_CYC - 1);
          uip <= 1'b1;
        end
        SQ_WARN: if (hold) begin
          st  <= SQ_IDLE;
          uip <= 1'b0;
        end else if (cnt == '0) begin
          st  <= SQ_BUSY;
          cnt <= CW'(UPD_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        SQ_BUSY: if (cnt == '0) begin
          st   <= SQ_IDLE;
          uip  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  time_t cur,
  input  logic  bin,
  input  logic  h24,
  input  logic  dst,
  input  logic  fall_done,
  output time_t nxt,
  output logic  fall_set,
  output logic  day_roll
);
  byte_t s, m, h, dw, d, mo, y, h12raw;
  byte_t ns, nm, nh, ndw, nd, nmo, ny, h12v, enc12;
  logic  at_159, spring, fall;

  always_comb begin
    s      = from_fmt(cur.sec, bin);
    m      = from_fmt(cur.mnt, bin);
    dw     = from_fmt(cur.dow, bin);
    d      = from_fmt(cur.date, bin);
    mo     = from_fmt(cur.mon, bin);
    y      = from_fmt(cur.year, bin);
    h12raw = from_fmt({1'b0, cur.hour[6:0]}, bin);
    if (h24) h = from_fmt(cur.hour, bin);
    else     h = ((h12raw == 8'd12) ? 8'd0 : h12raw) + (cur.hour[7] ? 8'd12 : 8'd0);

    at_159 = (h == 8'd1) && (m == 8'd59) && (s == 8'd59) && (dw == 8'd1);
    spring = dst && at_159 && (mo == 8'd4) && (d <= 8'd7);
    fall   = dst && at_159 && (mo == 8'd10) && (d >= 8'd25) && !fall_done;

    ns = s + 8'd1; nm = m; nh = h; ndw = dw; nd = d; nmo = mo; ny = y;
    fall_set = 1'b0;
    day_roll = 1'b0;
    if (spring) begin
      ns = 8'd0; nm = 8'd0; nh = 8'd3;
    end else if (fall) begin
      ns = 8'd0; nm = 8'd0; nh = 8'd1;
      fall_set = 1'b1;
    end else if (s >= 8'd59) begin
      ns = 8'd0;
      nm = m + 8'd1;
      if (m >= 8'd59) begin
        nm = 8'd0;
        nh = h + 8'd1;
        if (h >= 8'd23) begin
          nh       = 8'd0;
          day_roll = 1'b1;
          ndw      = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
          nd       = d + 8'd1;
          if (d >= month_days(mo, y)) begin
            nd  = 8'd1;
            nmo = mo + 8'd1;
            if (mo >= 8'd12) begin
              nmo = 8'd1;
              ny  = (y >= 8'd99) ? 8'd0 : y + 8'd1;
            end
          end
        end
      end
    end

    h12v  = (nh % 8'd12 == 8'd0) ? 8'd12 : nh % 8'd12;
    enc12 = to_fmt(h12v, bin);
    nxt.sec  = to_fmt(ns, bin);
    nxt.mnt  = to_fmt(nm, bin);
    nxt.hour = h24 ? to_fmt(nh, bin) : {(nh >= 8'd12), enc12[6:0]};
    nxt.dow  = to_fmt(ndw, bin);
    nxt.date = to_fmt(nd, bin);
    nxt.mon  = to_fmt(nmo, bin);
    nxt.year = to_fmt(ny, bin);
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
#(
  parameter int N = N_ALM
) (
  input  logic [N-1:0][BYTE_W-1:0] cur,
  input  logic [N-1:0][BYTE_W-1:0] alm,
  output logic                     all_match
);
  logic [N-1:0] hitv;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hitv[i] = (alm[i][BYTE_W-1 -: 2] == 2'b11) || (alm[i] == cur[i]);
  end

  assign all_match = &hitv;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int LEAD_CYC = 4,
  parameter int UPD_CYC  = 28,
  parameter int AW       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              ctl_set,
  input  logic              ctl_binary,
  input  logic              ctl_h24,
  input  logic              ctl_dst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] out_sec,
  output logic [BYTE_W-1:0] out_min,
  output logic [BYTE_W-1:0] out_hour,
  output logic [BYTE_W-1:0] out_dow,
  output logic [BYTE_W-1:0] out_date,
  output logic [BYTE_W-1:0] out_month,
  output logic [BYTE_W-1:0] out_year,
  output logic              uip,
  output logic              upd_done,
  output logic              alarm_hit
);
  time_t                           tm, nxt;
  logic [N_ALM-1:0][BYTE_W-1:0]    alm_q;
  logic                            fall_done, fall_set, day_roll;
  logic                            adv, fin, alm_all;

  rtc_update_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_1hz), .hold(ctl_set),
    .uip(uip), .adv(adv), .fin(fin), .done(upd_done)
  );

  rtc_advance u_adv (
    .cur(tm), .bin(ctl_binary), .h24(ctl_h24), .dst(ctl_dst),
    .fall_done(fall_done), .nxt(nxt), .fall_set(fall_set), .day_roll(day_roll)
  );

  rtc_alarm_match #(.N(N_ALM)) u_alm (
    .cur({tm.hour, tm.mnt, tm.sec}), .alm(alm_q), .all_match(alm_all)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tm        <= RESET_TIME;
      alm_q     <= '0;
      fall_done <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      alarm_hit <= fin && alm_all;
      if (adv) begin
        tm <= nxt;
        if (fall_set)      fall_done <= 1'b1;
        else if (day_roll) fall_done <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          AW'(A_SEC): tm.sec   <= wr_data;
          AW'(A_MIN): tm.mnt   <= wr_data;
          AW'(A_HR):  tm.hour  <= wr_data;
          AW'(A_DOW): tm.dow   <= wr_data;
          AW'(A_DAT): tm.date  <= wr_data;
          AW'(A_MON): tm.mon   <= wr_data;
          AW'(A_YR):  tm.year  <= wr_data;
          AW'(A_ALS): alm_q[0] <= wr_data;
          AW'(A_ALM): alm_q[1] <= wr_data;
          AW'(A_ALH): alm_q[2] <= wr_data;
          default: ;
        endcase
      end
    end
  end

  assign out_sec   = tm.sec;
  assign out_min   = tm.mnt;
  assign out_hour  = tm.hour;
  assign out_dow   = tm.dow;
  assign out_date  = tm.date;
  assign out_month = tm.mon;
  assign out_year  = tm.year;
endmodule

module rtc_calendar_core_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_set,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic [7:0]    out_sec,
  input logic          uip,
  input logic          upd_done,
  input logic          alarm_hit
);
  a_r2_done_ends_window: assert property (@(posedge clk) disable iff (rst)
    upd_done |-> $fell(uip));
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    upd_done |=> !upd_done);
  a_r3_hold_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (!uip && ctl_set) |=> !uip);
  a_r4_sec_quiet_outside_window: assert property (@(posedge clk) disable iff (rst)
    (!uip && !wr_en) |=> $stable(out_sec));
  a_r11_hit_with_done: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> upd_done);
  a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> (out_sec == $past(wr_data)));
endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ctl_set(ctl_set), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .out_sec(out_sec), .uip(uip), .upd_done(upd_done),
  .alarm_hit(alarm_hit)
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  localparam int LEAD = 4;
  localparam int UPD  = 28;

  logic clk = 0, rst = 1, tick_1hz = 0, ctl_set = 0, ctl_binary = 1, ctl_h24 = 1, ctl_dst = 0;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] out_sec, out_min, out_hour, out_dow, out_date, out_month, out_year;
  logic uip, upd_done, alarm_hit;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit seen_hit, seen_done, seen_uip;

  always #4 clk = ~clk;

  rtc_calendar_core #(.LEAD_CYC(LEAD), .UPD_CYC(UPD), .AW(4)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .ctl_set(ctl_set), .ctl_binary(ctl_binary),
    .ctl_h24(ctl_h24), .ctl_dst(ctl_dst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour), .out_dow(out_dow),
    .out_date(out_date), .out_month(out_month), .out_year(out_year),
    .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
  );

  // ---------------- reference model ----------------
  int rb[10];
  int m_st, m_cnt;
  bit m_uip, m_done, m_hit, m_fall;
  bit adv_now, fin_now, hit_now;

  function automatic int dec(int v, bit b);
    return b ? v : (v / 16) * 10 + v % 16;
  endfunction
  function automatic int enc(int v, bit b);
    return b ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int mdays(int mo, int y);
    case (mo)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  task automatic model_advance();
    int s, m, h, dw, d, mo, y, tod;
    bit b;
    b  = ctl_binary;
    s  = dec(rb[0], b);
    m  = dec(rb[1], b);
    if (ctl_h24) h = dec(rb[2], b);
    else h = (dec(rb[2] % 128, b) % 12) + ((rb[2] >= 128) ? 12 : 0);
    dw = dec(rb[3], b); d = dec(rb[4], b); mo = dec(rb[5], b); y = dec(rb[6], b);
    tod = h * 3600 + m * 60 + s;
    if (ctl_dst && tod == 7199 && dw == 1 && mo == 4 && d <= 7) tod = 10800;
    else if (ctl_dst && tod == 7199 && dw == 1 && mo == 10 && d >= 25 && !m_fall) begin
      tod = 3600; m_fall = 1;
    end else begin
      tod++;
      if (tod == 86400) begin
        tod = 0; m_fall = 0;
        dw = dw % 7 + 1;
        d++;
        if (d > mdays(mo, y)) begin
          d = 1; mo++;
          if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
        end
      end
    end
    h = tod / 3600; m = (tod / 60) % 60; s = tod % 60;
    rb[0] = enc(s, b); rb[1] = enc(m, b);
    if (ctl_h24) rb[2] = enc(h, b);
    else rb[2] = ((h >= 12) ? 128 : 0) + enc((h % 12 == 0) ? 12 : h % 12, b);
    rb[3] = enc(dw, b); rb[4] = enc(d, b); rb[5] = enc(mo, b); rb[6] = enc(y, b);
  endtask

  function automatic bit amatch(int i);
    return (rb[7 + i] / 64 == 3) || (rb[7 + i] == rb[i]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rb = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 0};
      m_st = 0; m_cnt = 0; m_uip = 0; m_done = 0; m_hit = 0; m_fall = 0;
    end else begin
      adv_now = (m_st == 1 && m_cnt == 0 && !ctl_set);
      fin_now = (m_st == 2 && m_cnt == 0);
      hit_now = fin_now && amatch(0) && amatch(1) && amatch(2);
      if (adv_now) model_advance();
      if (wr_en && wr_addr < 10) rb[wr_addr] = wr_data;
      m_done = fin_now; m_hit = hit_now;
      case (m_st)
        0: if (tick_1hz && !ctl_set) begin m_st = 1; m_cnt = LEAD - 1; end
        1: if (ctl_set) m_st = 0;
           else if (m_cnt == 0) begin m_st = 2; m_cnt = UPD - 1; end
           else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      m_uip = (m_st != 0);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R4 model sec",   out_sec,   rb[0]);
      chk("R4 model min",   out_min,   rb[1]);
      chk("R6 model hour",  out_hour,  rb[2]);
      chk("R8 model dow",   out_dow,   rb[3]);
      chk("R7 model date",  out_date,  rb[4]);
      chk("R7 model month", out_month, rb[5]);
      chk("R7 model year",  out_year,  rb[6]);
      chk("R2 model uip",   uip,       m_uip);
      chk("R2 model done",  upd_done,  m_done);
      chk("R11 model hit",  alarm_hit, m_hit);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load(int s, int m, int h, int dw, int d, int mo, int y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  task automatic step();
    seen_done = 0; seen_hit = 0;
    tick_1hz = 1;
    @(negedge clk);
    tick_1hz = 0;
    for (int i = 0; i < LEAD + UPD + 8; i++) begin
      @(negedge clk);
      if (upd_done) begin seen_done = 1; seen_hit = alarm_hit; break; end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 sec", out_sec, 0);  chk("R1 hour", out_hour, 0);
    chk("R1 dow", out_dow, 1);  chk("R1 date", out_date, 1);
    chk("R1 month", out_month, 1); chk("R1 year", out_year, 0);
    chk("R1 uip", uip, 0);      chk("R1 done", upd_done, 0);

    // R2 timing, R4/R7/R8/R13 binary full rollover
    load(59, 59, 23, 7, 31, 12, 99);
    chk("R13 write year", out_year, 99);
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    chk("R2 uip raised", uip, 1);
    repeat (LEAD - 1) @(negedge clk);
    chk("R2 no early advance", out_sec, 59);
    @(negedge clk);
    chk("R2 advanced", out_sec, 0);
    repeat (UPD - 1) @(negedge clk);
    chk("R2 uip still high", uip, 1);
    @(negedge clk);
    chk("R2 uip fell", uip, 0); chk("R2 done pulse", upd_done, 1);
    @(negedge clk);
    chk("R2 done one cycle", upd_done, 0);
    chk("R4 hour wrap", out_hour, 0); chk("R4 min wrap", out_min, 0);
    chk("R8 dow wrap", out_dow, 1);   chk("R7 date wrap", out_date, 1);
    chk("R7 month wrap", out_month, 1); chk("R7 year wrap", out_year, 0);

    // R7 30-day month
    load(59, 59, 23, 2, 30, 4, 25); step();
    chk("R7 april 30 date", out_date, 1); chk("R7 april 30 month", out_month, 5);

    // R5 BCD
    ctl_binary = 0;
    load(8'h59, 8'h59, 8'h09, 2, 8'h10, 8'h05, 8'h24); step();
    chk("R5 bcd hour", out_hour, 8'h10); chk("R5 bcd min", out_min, 8'h00);

    // R6 12-hour BCD, R7 leap
    ctl_h24 = 0;
    load(8'h59, 8'h59, 8'h11, 2, 8'h10, 8'h05, 8'h24); step();
    chk("R6 noon", out_hour, 8'h92);
    wr(0, 8'h59); wr(1, 8'h59); step();
    chk("R6 one pm", out_hour, 8'h81);
    load(8'h59, 8'h59, 8'h91, 3, 8'h28, 8'h02, 8'h24); step();
    chk("R6 midnight", out_hour, 8'h12); chk("R7 leap feb 29", out_date, 8'h29);
    load(8'h59, 8'h59, 8'h91, 3, 8'h28, 8'h02, 8'h23); step();
    chk("R7 common feb date", out_date, 8'h01); chk("R7 common feb month", out_month, 8'h03);
    chk("R8 dow step", out_dow, 4);

    // R3 hold
    ctl_binary = 1; ctl_h24 = 1;
    load(10, 20, 5, 2, 3, 6, 24);
    ctl_set = 1; seen_uip = 0;
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    for (int i = 0; i < LEAD + UPD + 4; i++) begin
      @(negedge clk); if (uip) seen_uip = 1;
    end
    chk("R3 hold no uip", seen_uip, 0); chk("R3 hold sec", out_sec, 10);
    ctl_set = 0;
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    ctl_set = 1; @(negedge clk);
    chk("R3 cancel drops uip", uip, 0);
    ctl_set = 0; seen_done = 0;
    for (int i = 0; i < LEAD + UPD + 4; i++) begin
      @(negedge clk); if (upd_done) seen_done = 1;
    end
    chk("R3 cancel no done", seen_done, 0); chk("R3 cancel sec", out_sec, 10);

    // R9 / R10 daylight saving
    ctl_dst = 1;
    load(59, 59, 1, 1, 5, 4, 24); step();
    chk("R9 spring hour", out_hour, 3); chk("R9 spring min", out_min, 0);
    load(59, 59, 1, 1, 27, 10, 24); step();
    chk("R10 fall hour", out_hour, 1); chk("R10 fall sec", out_sec, 0);
    wr(0, 59); wr(1, 59); step();
    chk("R10 fall once", out_hour, 2);
    ctl_dst = 0;

    // R11 alarm
    load(4, 0, 0, 2, 3, 6, 24);
    wr(7, 5); wr(8, 0); wr(9, 0); step();
    chk("R11 exact match", seen_hit, 1); chk("R11 with done", seen_done, 1);
    wr(7, 8'hC0); step();
    chk("R11 dont care", seen_hit, 1);
    wr(8, 1); step();
    chk("R11 mismatch", seen_hit, 0);
    wr(12, 33); @(negedge clk);
    chk("R13 bad address", out_sec, 7);

    // R12 write lands on advance edge
    load(59, 5, 10, 2, 3, 6, 24);
    tick_1hz = 1; @(negedge clk); tick_1hz = 0;
    repeat (LEAD - 1) @(negedge clk);
    wr(0, 7);
    chk("R12 written sec", out_sec, 7); chk("R12 carried min", out_min, 6);
    repeat (UPD + 4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule